// File: doc/BRIEF.md
# Scale-Space Cube Peak Detector

This block decides, for a row of detector responses, which positions are local peaks in a three-dimensional neighbourhood spanning x, y and scale. The neighbourhood is a 3x3x3 cube. It is three columns wide and three rows tall, and it covers three adjacent scale layers. A position becomes an interest point when its response is strictly larger than all 26 surrounding values and also above a programmable threshold.

Responses arrive as vertical slices, one column at a time, from the left edge of the row to the right. Each slice takes three beats, top row first. Every beat carries one value from each of the lower, middle and upper layers. The block holds the two previous slices, so each new slice completes a cube that overlaps the previous one by two columns. At full input rate this gives a cube every three cycles. Each cube goes through a seven-register comparison pipeline. A detection is reported with the column of the cube centre and with the row number and layer index given at the start of the line.

Top module: `ss_nms_3d`

## Requirements
- R1: After reset, `det_valid` is low, and it stays low until a complete cube has been judged.
- R2: A beat is accepted when `in_valid` is high. The beats of a slice carry rows 0, 1 and 2 in that order. `in_lo`, `in_mid` and `in_hi` carry the lower, middle and upper layer. The third beat completes the slice and advances the column by one.
- R3: Responses and `thresh` are signed two's-complement values. A cube is flagged when its centre value (middle slice, row 1, middle layer) is greater than each of its 26 neighbours and greater than `thresh`.
- R4: If any neighbour equals the centre value, the cube is not flagged.
- R5: If the centre value equals `thresh`, the cube is not flagged.
- R6: A detection reports `det_x` as the 0-based column of the centre slice, counted from the start of the line. `det_y` and `det_layer` are the values that were on `line_y` and `line_layer` at the line's first beat.
- R7: `det_valid` rises on the seventh rising edge counted from, and including, the edge that accepts the third beat of the slice to the right of the centre. It stays high for one cycle.
- R8: No detection is reported for centre column 0 or for column LINE_W-1. Slices after the first LINE_W of a line are ignored.
- R9: A beat with `in_first` high starts a new line. It is row 0 of column 0, and any partial slice or earlier slices can no longer take part in a cube.
- R10: Cycles with `in_valid` low change nothing. A slice interrupted by idle cycles is judged exactly as if it had been sent without gaps.
- R11: Two detections are at least three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat qualifier |
| in_first | input | 1 | First beat of a line |
| in_lo | input | DW | Lower-layer response for the current row |
| in_mid | input | DW | Middle-layer response for the current row |
| in_hi | input | DW | Upper-layer response for the current row |
| line_y | input | YW | Row number of the line, sampled on its first beat |
| line_layer | input | LW | Layer index of the line, sampled on its first beat |
| thresh | input | DW | Signed detection threshold |
| det_valid | output | 1 | One-cycle detection strobe |
| det_x | output | $clog2(LINE_W) | Column of the detected point |
| det_y | output | YW | Row of the detected point |
| det_layer | output | LW | Layer of the detected point |

## Verification
The assertions check four properties on every cycle:
- the strobe is low out of reset;
- no detection reports an edge column;
- strobes are spaced at least three cycles apart;
- every strobe has an accepted beat exactly seven cycles before it.

Whether the peak decision itself is right can only be shown by the bench's scenarios, and the same holds for the reported coordinates. These scenarios cover strict ties across the layers, a centre equal to the threshold, negative responses, a line restarted in the middle of a slice, overlong lines, and slices broken up by idle cycles.

// File: rtl/ss_nms_3d.sv
module ss_nms_3d #(
  parameter int DW     = 22,
  parameter int LINE_W = 512,
  parameter int YW     = 9,
  parameter int LW     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_first,
  input  logic signed [DW-1:0] in_lo,
  input  logic signed [DW-1:0] in_mid,
  input  logic signed [DW-1:0] in_hi,
  input  logic [YW-1:0]        line_y,
  input  logic [LW-1:0]        line_layer,
  input  logic signed [DW-1:0] thresh,
  output logic                 det_valid,
  output logic [$clog2(LINE_W)-1:0] det_x,
  output logic [YW-1:0]        det_y,
  output logic [LW-1:0]        det_layer
);

  localparam int XW = $clog2(LINE_W);
  localparam int CW = $clog2(LINE_W + 1);
  localparam int NB = 26;

  function automatic logic signed [DW-1:0] smax(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [1:0]          rc;
  logic [CW-1:0]       col;
  logic [YW-1:0]       y_q;
  logic [LW-1:0]       l_q;
  logic signed [DW-1:0] s0 [2][3];
  logic signed [DW-1:0] s1 [3][3];
  logic signed [DW-1:0] s2 [3][3];
  logic signed [DW-1:0] inrow [3];

  logic [1:0]    rc_e;
  logic [CW-1:0] col_e;
  logic          take, slice_done, fire;

  assign rc_e       = in_first ? 2'd0 : rc;
  assign col_e      = in_first ? '0 : col;
  assign take       = in_valid && (col_e < CW'(LINE_W));
  assign slice_done = take && (rc_e == 2'd2);
  assign fire       = slice_done && (col_e >= CW'(2));
  assign inrow[0]   = in_lo;
  assign inrow[1]   = in_mid;
  assign inrow[2]   = in_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc  <= '0;
      col <= '0;
    end else if (in_valid) begin
      if (in_first) begin
        y_q <= line_y;
        l_q <= line_layer;
      end
      if (take) begin
        if (slice_done) begin
          rc  <= '0;
          col <= col_e + CW'(1);
          for (int r = 0; r < 3; r++)
            for (int l = 0; l < 3; l++) begin
              s2[r][l] <= s1[r][l];
              s1[r][l] <= (r == 2) ? inrow[l] : s0[r[0]][l];
            end
        end else begin
          rc  <= rc_e + 2'd1;
          col <= col_e;
          for (int l = 0; l < 3; l++) s0[rc_e[0]][l] <= inrow[l];
        end
      end else begin
        rc  <= rc_e;
        col <= col_e;
      end
    end
  end

  logic signed [DW-1:0] cb [3][3][3];
  logic signed [DW-1:0] nb [NB];

  always_comb begin
    for (int r = 0; r < 3; r++)
      for (int l = 0; l < 3; l++) begin
        cb[0][r][l] = s2[r][l];
        cb[1][r][l] = s1[r][l];
        cb[2][r][l] = (r == 2) ? inrow[l] : s0[r[0]][l];
      end
  end

  always_comb begin
    int n;
    n = 0;
    for (int k = 0; k < 3; k++)
      for (int r = 0; r < 3; r++)
        for (int l = 0; l < 3; l++)
          if (!(k == 1 && r == 1 && l == 1)) begin
            nb[n] = cb[k][r][l];
            n = n + 1;
          end
  end

  logic                 vld_p   [1:6];
  logic                 above_p [1:6];
  logic signed [DW-1:0] ctr_p   [1:6];
  logic [XW-1:0]        x_p     [1:6];
  logic [YW-1:0]        y_p     [1:6];
  logic [LW-1:0]        l_p     [1:6];

  logic signed [DW-1:0] m1 [NB];
  logic signed [DW-1:0] m2 [13];
  logic signed [DW-1:0] m3 [7];
  logic signed [DW-1:0] m4 [4];
  logic signed [DW-1:0] m5 [2];
  logic signed [DW-1:0] m6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= 6; i++) vld_p[i] <= 1'b0;
      det_valid <= 1'b0;
    end else begin
      vld_p[1] <= fire;
      for (int i = 2; i <= 6; i++) vld_p[i] <= vld_p[i-1];
      det_valid <= vld_p[6] && above_p[6] && (ctr_p[6] > m6);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) m1[i] <= nb[i];
    ctr_p[1]   <= cb[1][1][1];
    above_p[1] <= cb[1][1][1] > thresh;
    x_p[1]     <= XW'(col_e - CW'(1));
    y_p[1]     <= y_q;
    l_p[1]     <= l_q;
    for (int i = 2; i <= 6; i++) begin
      ctr_p[i]   <= ctr_p[i-1];
      above_p[i] <= above_p[i-1];
      x_p[i]     <= x_p[i-1];
      y_p[i]     <= y_p[i-1];
      l_p[i]     <= l_p[i-1];
    end
    for (int i = 0; i < 13; i++) m2[i] <= smax(m1[2*i], m1[2*i+1]);
    for (int i = 0; i < 6; i++)  m3[i] <= smax(m2[2*i], m2[2*i+1]);
    m3[6] <= m2[12];
    for (int i = 0; i < 3; i++)  m4[i] <= smax(m3[2*i], m3[2*i+1]);
    m4[3] <= m3[6];
    m5[0] <= smax(m4[0], m4[1]);
    m5[1] <= smax(m4[2], m4[3]);
    m6    <= smax(m5[0], m5[1]);
    det_x     <= x_p[6];
    det_y     <= y_p[6];
    det_layer <= l_p[6];
  end

endmodule

// File: rtl/ss_nms_3d_chk.sv
module ss_nms_3d_chk #(
  parameter int LINE_W = 512
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic                      det_valid,
  input logic [$clog2(LINE_W)-1:0] det_x
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !det_valid);

  // R8
  edge_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> (det_x != '0) && (int'(det_x) < LINE_W - 1));

  // R11
  spacing_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |=> !det_valid);

  // R11
  spacing_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |=> ##1 !det_valid);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_valid |-> $past(in_valid, 7));

endmodule

bind ss_nms_3d ss_nms_3d_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .det_valid(det_valid), .det_x(det_x)
);

// File: tb/test_ss_nms_3d.sv
`timescale 1ns/1ps
module test_ss_nms_3d;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0;
  logic signed [21:0] in_lo = '0, in_mid = '0, in_hi = '0, thresh = '0;
  logic [8:0] line_y = '0;
  logic [2:0] line_layer = '0;
  logic det_valid;
  logic [2:0] det_x;
  logic [8:0] det_y;
  logic [2:0] det_layer;

  ss_nms_3d #(.DW(22), .LINE_W(W), .YW(9), .LW(3)) i_ss_nms_3d (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_lo(in_lo), .in_mid(in_mid), .in_hi(in_hi), .line_y(line_y),
    .line_layer(line_layer), .thresh(thresh), .det_valid(det_valid),
    .det_x(det_x), .det_y(det_y), .det_layer(det_layer));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_det = -10;
  int det_seen = 0, last_x = -1, last_y = -1, last_l = -1;
  bit done = 0, stall = 0;

  int m_rc = 0, m_col = 0, m_y = 0, m_l = 0;
  int sl [0:W-1][0:2][0:2];
  int pv [0:6], px [0:6], py [0:6], pl [0:6];
  int g  [0:11][0:2][0:2];

  initial for (int i = 0; i < 7; i++) pv[i] = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_rc = 0; m_col = 0;
      for (int i = 0; i < 7; i++) pv[i] = 0;
    end else begin
      for (int i = 6; i > 0; i--) begin
        pv[i] = pv[i-1]; px[i] = px[i-1]; py[i] = py[i-1]; pl[i] = pl[i-1];
      end
      pv[0] = 0;
      if (in_valid) begin
        if (in_first) begin m_rc = 0; m_col = 0; m_y = line_y; m_l = line_layer; end
        if (m_col < W) begin
          sl[m_col][m_rc][0] = in_lo;
          sl[m_col][m_rc][1] = in_mid;
          sl[m_col][m_rc][2] = in_hi;
          if (m_rc == 2) begin
            if (m_col >= 2) begin
              int c; bit ok;
              c = sl[m_col-1][1][1];
              ok = c > int'(thresh);
              for (int k = 0; k < 3; k++)
                for (int r = 0; r < 3; r++)
                  for (int l = 0; l < 3; l++)
                    if (!(k == 1 && r == 1 && l == 1) && sl[m_col-2+k][r][l] >= c) ok = 0;
              pv[0] = ok; px[0] = m_col - 1; py[0] = m_y; pl[0] = m_l;
            end
            m_col = m_col + 1; m_rc = 0;
          end else m_rc = m_rc + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (det_valid !== pv[6][0] ||
          (pv[6] != 0 && (int'(det_x) != px[6] || int'(det_y) != py[6] || int'(det_layer) != pl[6]))) begin
        fails++;
        $display("FAIL R2/R3/R6/R7 cycle %0d: valid=%0d x=%0d y=%0d l=%0d expected valid=%0d x=%0d y=%0d l=%0d",
                 cyc, det_valid, det_x, det_y, det_layer, pv[6], px[6], py[6], pl[6]);
      end
      if (det_valid === 1'b1) begin
        checks++;
        if (cyc - last_det < 3) begin
          fails++;
          $display("FAIL R11 cycle %0d: spacing %0d expected >= 3", cyc, cyc - last_det);
        end
        last_det = cyc; det_seen++;
        last_x = det_x; last_y = det_y; last_l = det_layer;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic beat(bit f, int a, int b, int c);
    @(negedge clk);
    in_valid = 1'b1; in_first = f; in_lo = 22'(a); in_mid = 22'(b); in_hi = 22'(c);
    if (stall && ($urandom % 3 == 0)) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(int v);
    for (int c = 0; c < 12; c++)
      for (int r = 0; r < 3; r++)
        for (int l = 0; l < 3; l++) g[c][r][l] = v;
  endtask

  task automatic send_line(int n, int y, int lay);
    line_y = 9'(y); line_layer = 3'(lay);
    for (int c = 0; c < n; c++)
      for (int r = 0; r < 3; r++)
        beat(c == 0 && r == 0, g[c][r][0], g[c][r][1], g[c][r][2]);
  endtask

  task automatic run(string tag, int n, int y, int lay, int exp);
    int base;
    base = det_seen;
    send_line(n, y, lay);
    idle(12);
    chk(tag, det_seen - base, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset", det_valid, 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 idle", det_valid, 0);

    clear(0); thresh = 50; g[3][1][1] = 100;
    run("R3 single peak", W, 5, 2, 1);
    chk("R6 x", last_x, 3); chk("R6 y", last_y, 5); chk("R6 layer", last_l, 2);

    clear(0); g[3][1][1] = 100; g[4][1][1] = 100;
    run("R4 tie same layer", W, 1, 1, 0);
    clear(0); g[3][1][1] = 100; g[2][0][2] = 100;
    run("R4 tie upper layer", W, 1, 1, 0);

    clear(0); g[3][1][1] = 50; thresh = 50;
    run("R5 equal threshold", W, 2, 0, 0);
    thresh = 49;
    run("R5 below threshold", W, 2, 0, 1);

    clear(0); thresh = 50; g[0][1][1] = 100; g[7][1][1] = 100;
    run("R8 edge columns", W, 3, 3, 0);
    clear(0); g[1][1][1] = 100; g[6][1][1] = 100;
    run("R8 inner edge columns", W, 3, 3, 2);
    clear(0); g[9][1][1] = 100;
    run("R8 beyond width", 11, 4, 4, 0);

    clear(-1000); g[4][1][1] = -10; thresh = -20;
    run("R3 negative values", W, 6, 5, 1);
    chk("R3 negative x", last_x, 4);

    clear(200); thresh = 50;
    line_y = 9'd0;
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 3; r++) beat(c == 0 && r == 0, 200, 200, 200);
    beat(0, 200, 200, 200); beat(0, 200, 200, 200);
    clear(0); g[2][1][1] = 100;
    run("R9 restart mid-slice", 5, 7, 1, 1);
    chk("R9 x", last_x, 2); chk("R9 y", last_y, 7);

    stall = 1;
    clear(0); g[5][1][1] = 100;
    run("R10 stalled slices", W, 8, 6, 1);
    chk("R10 x", last_x, 5);

    for (int t = 0; t < 60; t++) begin
      for (int c = 0; c < 12; c++)
        for (int r = 0; r < 3; r++)
          for (int l = 0; l < 3; l++) g[c][r][l] = int'($urandom_range(60)) - 30;
      thresh = 22'(int'($urandom_range(40)) - 20);
      stall = (t % 2 == 1);
      send_line((t % 5 == 0) ? 10 : W, t, t % 8);
    end
    stall = 0;
    idle(12);
    chk("R2 random lines produced detections", (det_seen > 5) ? 1 : 0, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule